// File: doc/BRIEF.md
# General-Purpose Register File with Link Write

This block is the integer register file of a 32-bit load-store core. It holds thirty-two 32-bit registers. Two read ports return operands combinationally from 5-bit register numbers. One write port updates the selected register on the rising clock edge.

Register 0 is a constant zero: writes to it are dropped and reads of it return 0. A separate link input writes a return address into register 31 in the same cycle as the normal port. A call can therefore save its return address while another result is retired. The decode stage drives the two read addresses. Write-back drives the write port, and the jump-and-link path drives the link input.

A parameter chooses whether a read of the register being written in the same cycle sees the old or the new value. By default it sees the old value.

Top module: `gpr_file`

## Requirements
- R1: While rst_n is low at a rising clock edge, every register is cleared to zero and any write or link request in that cycle is ignored; after reset every address reads 0 on both ports.
- R2: When wr_en is 1 at a rising edge, the register numbered wr_addr (1 to 30, or 31 without a link write) takes wr_data and reads return it from the next cycle on.
- R3: When wr_en and link_en are both 0 at a rising edge, no register changes, whatever wr_addr and wr_data hold.
- R4: A read of register 0 returns 0 on either port, also after a write with wr_addr = 0 and nonzero wr_data.
- R5: The two read ports are independent: rd_data_a shows register rd_addr_a and rd_data_b shows register rd_addr_b in the same cycle, including when both addresses are equal.
- R6: When link_en is 1 at a rising edge, register 31 takes link_data.
- R7: When link_en is 1 and wr_en is 1 with wr_addr = 31 at the same edge, register 31 takes link_data and wr_data is discarded.
- R8: When link_en is 1 and wr_en is 1 with wr_addr other than 0 and 31, both registers are updated at that edge.
- R9: With the default BYPASS = 0, a read of the register being written returns its old value until the write edge has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_addr_a | input | 5 | Register number for read port A |
| rd_data_a | output | 32 | Contents of register rd_addr_a |
| rd_addr_b | input | 5 | Register number for read port B |
| rd_data_b | output | 32 | Contents of register rd_addr_b |
| wr_en | input | 1 | Normal write enable |
| wr_addr | input | 5 | Register number for the normal write |
| wr_data | input | 32 | Data for the normal write |
| link_en | input | 1 | Return-address write enable for register 31 |
| link_data | input | 32 | Return address to store in register 31 |

## Verification
The hardest situation to reach is a collision in a single edge: a link write and a normal write aimed at register 31 together, or a read of the register that is being written in that same cycle. The stimulus sets the write, link and read inputs together at the falling edge. Read results are sampled before the next rising edge to see the old contents, and sampled again afterwards to see which source won. A reset is also applied while write requests are active, so that the clear must override them.

// File: rtl/gpr_pkg.sv
// Package: shared defaults and types for the general-purpose register file.
// Assumes: consumers take widths from module parameters; these are defaults only.
package gpr_pkg;
    localparam int unsigned GPR_DATA_W = 32;
    localparam int unsigned GPR_ADDR_W = 5;

    // Which source updates a given register at the coming edge.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PORT = 2'd1,
        SRC_LINK = 2'd2
    } wr_src_t;
endpackage

// File: rtl/gpr_write_sel.sv
// Module: gpr_write_sel
// Turns the normal write port and the link input into one write enable and
// one data word per register. Register 0 never gets an enable. At the link
// register the link input takes priority over the normal port.
// Assumes: inputs are stable around the rising clock edge; purely combinational.
module gpr_write_sel #(
    parameter int unsigned DATA_W   = gpr_pkg::GPR_DATA_W,
    parameter int unsigned ADDR_W   = gpr_pkg::GPR_ADDR_W,
    parameter int unsigned NREGS    = 1 << ADDR_W,
    parameter int unsigned LINK_IDX = NREGS - 1
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic                          link_en,
    input  logic [DATA_W-1:0]             link_data,
    output logic [NREGS-1:0]              we_vec,
    output logic [NREGS-1:0][DATA_W-1:0]  wd_vec
);
    import gpr_pkg::*;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            // Register 0: never written.
            assign we_vec[i] = 1'b0;
            assign wd_vec[i] = '0;
        end else if (i == LINK_IDX) begin : g_link
            wr_src_t src;
            // Pick the winning source for the link register: link first.
            always_comb begin
                if (link_en)
                    src = SRC_LINK;
                else if (wr_en && (wr_addr == ADDR_W'(i)))
                    src = SRC_PORT;
                else
                    src = SRC_NONE;
            end
            assign we_vec[i] = (src != SRC_NONE);
            assign wd_vec[i] = (src == SRC_LINK) ? link_data : wr_data;
        end else begin : g_plain
            // Ordinary register: only the normal port writes it.
            assign we_vec[i] = wr_en && (wr_addr == ADDR_W'(i));
            assign wd_vec[i] = wr_data;
        end
    end
endmodule

// File: rtl/gpr_storage.sv
// Module: gpr_storage
// Holds registers 1 to NREGS-1 as flops; slot 0 is a constant zero.
// Assumes: at most one source per register was already chosen upstream;
// reset is synchronous, active low, and overrides any write.
module gpr_storage #(
    parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W,
    parameter int unsigned NREGS  = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NREGS-1:1]              we,
    input  logic [NREGS-1:1][DATA_W-1:0]  wd,
    output logic [NREGS-1:0][DATA_W-1:0]  q
);
    assign q[0] = '0;

    for (genvar i = 1; i < NREGS; i++) begin : g_cell
        // One register: clear on reset, else load when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wd[i];
        end
    end
endmodule

// File: rtl/gpr_read_mux.sv
// Module: gpr_read_mux
// One combinational read port. With BYPASS set, a register being written
// this cycle returns the incoming data; otherwise it returns stored contents.
// Assumes: q[0] and we[0] are zero, so register 0 reads zero either way.
module gpr_read_mux #(
    parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W,
    parameter int unsigned ADDR_W = gpr_pkg::GPR_ADDR_W,
    parameter int unsigned NREGS  = 1 << ADDR_W,
    parameter bit          BYPASS = 1'b0
) (
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic [NREGS-1:0][DATA_W-1:0]  q,
    input  logic [NREGS-1:0]              we,
    input  logic [NREGS-1:0][DATA_W-1:0]  wd,
    output logic [DATA_W-1:0]             rd_data
);
    // Select the stored word, or the incoming one when bypass is enabled.
    always_comb begin
        if (BYPASS && we[rd_addr])
            rd_data = wd[rd_addr];
        else
            rd_data = q[rd_addr];
    end
endmodule

// File: rtl/gpr_file.sv
// Module: gpr_file (top)
// Register file with two combinational read ports, one clocked write port,
// a link write into the top register, and register 0 fixed at zero.
// Assumes: single clock domain; synchronous active-low reset.
module gpr_file #(
    parameter int unsigned DATA_W = gpr_pkg::GPR_DATA_W,
    parameter int unsigned ADDR_W = gpr_pkg::GPR_ADDR_W,
    parameter bit          BYPASS = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [DATA_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [DATA_W-1:0] rd_data_b,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [DATA_W-1:0] link_data
);
    localparam int unsigned NREGS    = 1 << ADDR_W;
    localparam int unsigned LINK_IDX = NREGS - 1;
    localparam int unsigned NUM_RD   = 2;

    logic [NREGS-1:0]              we_vec;
    logic [NREGS-1:0][DATA_W-1:0]  wd_vec;
    logic [NREGS-1:0][DATA_W-1:0]  q_vec;
    logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_vec;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data_vec;

    assign rd_addr_vec[0] = rd_addr_a;
    assign rd_addr_vec[1] = rd_addr_b;
    assign rd_data_a      = rd_data_vec[0];
    assign rd_data_b      = rd_data_vec[1];

    gpr_write_sel #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREGS(NREGS), .LINK_IDX(LINK_IDX)
    ) u_wsel (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data),
        .we_vec(we_vec), .wd_vec(wd_vec)
    );

    gpr_storage #(
        .DATA_W(DATA_W), .NREGS(NREGS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(we_vec[NREGS-1:1]), .wd(wd_vec[NREGS-1:1]),
        .q(q_vec)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        gpr_read_mux #(
            .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREGS(NREGS), .BYPASS(BYPASS)
        ) u_rmux (
            .rd_addr(rd_addr_vec[p]), .q(q_vec), .we(we_vec), .wd(wd_vec),
            .rd_data(rd_data_vec[p])
        );
    end
endmodule

// File: rtl/gpr_file_chk.sv
// Module: gpr_file_chk
// Port-level properties of gpr_file, bound into every instance.
// Assumes: BYPASS = 0 for the properties that look at next-cycle reads.
module gpr_file_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter bit          BYPASS = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              link_en,
    input logic [DATA_W-1:0] link_data
);
    localparam logic [ADDR_W-1:0] TOP_REG = '1;

    logic armed;
    // Set once a reset edge has been seen, so $past has real history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
    end

    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(rst_n)) |-> (rd_data_a == '0 && rd_data_b == '0));

    a_r4_zero_reads_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    a_r4_zero_reads_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !BYPASS && $past(rst_n) && $past(wr_en) && $past(wr_addr) != '0
         && !($past(link_en) && $past(wr_addr) == TOP_REG)
         && rd_addr_a == $past(wr_addr))
        |-> (rd_data_a == $past(wr_data)));

    a_r6_link_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n) && $past(link_en) && rd_addr_b == TOP_REG)
        |-> (rd_data_b == $past(link_data)));

    a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rst_n) && !$past(wr_en) && !$past(link_en)
         && rd_addr_a == $past(rd_addr_a))
        |-> $stable(rd_data_a));
endmodule

bind gpr_file gpr_file_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BYPASS(BYPASS)
) u_chk (.*);

// File: tb/gpr_file_bench.sv
`timescale 1ns/100ps
module gpr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0, link_data = '0;
    logic        wr_en = 1'b0, link_en = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [32];

    typedef struct {
        int          port;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t exp_q[$];
    event  mon_ev;

    always #2 clk = ~clk;

    gpr_file u_gpr_file (
        .clk(clk), .rst_n(rst_n),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_en(link_en), .link_data(link_data)
    );

    // Monitor: pops queued expectations and compares them with the read ports.
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [31:0] got;
                it  = exp_q.pop_front();
                got = (it.port == 0) ? rd_data_a : rd_data_b;
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s port %0d: got %h expected %h", it.req, it.port, got, it.exp);
                end
            end
        end
    end

    // Driver: put addresses on both ports, queue expectations, trigger monitor.
    task automatic expect_reads(input logic [4:0] a, input logic [4:0] b, input string req);
        rd_addr_a = a;
        rd_addr_b = b;
        exp_q.push_back('{0, model[a], req});
        exp_q.push_back('{1, model[b], req});
        #0.5;
        -> mon_ev;
        #0.5;
    endtask

    // Apply one write cycle and update the reference model by the requirements.
    task automatic do_write(input logic en, input logic [4:0] addr, input logic [31:0] d,
                            input logic len, input logic [31:0] ld);
        @(negedge clk);
        wr_en = en; wr_addr = addr; wr_data = d;
        link_en = len; link_data = ld;
        @(posedge clk);
        if (rst_n) begin
            if (en && addr != 5'd0 && !(len && addr == 5'd31)) model[addr] = d;
            if (len) model[31] = ld;
        end
        #0.5;
        wr_en = 1'b0; link_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 5'd12; wr_data = 32'hDEAD_0012;
        link_en = 1'b1; link_data = 32'hDEAD_0031;
        repeat (2) @(posedge clk);
        for (int i = 0; i < 32; i++) model[i] = '0;
        @(negedge clk);
        rst_n = 1'b1; wr_en = 1'b0; link_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 32; i += 2) expect_reads(5'(i), 5'(i + 1), req);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < 32; i++) model[i] = '0;
        do_reset();
        @(negedge clk);
        check_all("R1");                               // R1: cleared after reset

        for (int i = 1; i < 31; i++)                   // R2: fill registers 1..30
            do_write(1'b1, 5'(i), 32'h1000_0000 + 32'(i) * 32'h0101_0101, 1'b0, '0);
        @(negedge clk);
        check_all("R2");
        expect_reads(5'd7, 5'd7, "R5");                // R5: same address on both ports
        expect_reads(5'd30, 5'd3, "R5");               // R5: different addresses

        do_write(1'b0, 5'd7, 32'hBAD0_BAD0, 1'b0, '0); // R3: disabled write
        @(negedge clk);
        expect_reads(5'd7, 5'd8, "R3");

        do_write(1'b1, 5'd0, 32'hFFFF_FFFF, 1'b0, '0); // R4: write to register 0
        @(negedge clk);
        expect_reads(5'd0, 5'd0, "R4");

        do_write(1'b0, 5'd0, '0, 1'b1, 32'h0040_1234); // R6: link write only
        @(negedge clk);
        expect_reads(5'd31, 5'd30, "R6");

        do_write(1'b1, 5'd31, 32'h5555_AAAA, 1'b1, 32'h0040_2000); // R7: collision at 31
        @(negedge clk);
        expect_reads(5'd31, 5'd31, "R7");

        do_write(1'b1, 5'd9, 32'h0909_0909, 1'b1, 32'h0040_3000); // R8: both land
        @(negedge clk);
        expect_reads(5'd9, 5'd31, "R8");

        @(negedge clk);                                // R9: read during write
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hC0DE_0005;
        expect_reads(5'd5, 5'd5, "R9");
        @(posedge clk);
        model[5] = 32'hC0DE_0005;
        #0.5;
        wr_en = 1'b0;
        @(negedge clk);
        expect_reads(5'd5, 5'd4, "R9");

        lfsr = 32'hACE1_2345;                          // R2/R7/R8: mixed pattern
        for (int n = 0; n < 150; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            do_write(lfsr[3], lfsr[8:4], lfsr ^ 32'h3C3C_3C3C, lfsr[12] & lfsr[13], ~lfsr);
            @(negedge clk);
            expect_reads(lfsr[20:16], lfsr[8:4], "R2");
        end

        do_reset();                                    // R1: reset with writes pending
        @(negedge clk);
        check_all("R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule